// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers eleven hardware interrupt events from timers, a serial interface, a supply monitor and four asynchronous port pins. It folds them onto eight priority levels, numbered 0 to 7, and offers the processor core a single request together with the level number and a fixed program-memory vector address. Each hardware source has its own enable bit. Level 0 has no hardware source and can only be raised by software. Software can set pending bits on any level through a small write port. Work can therefore be re-prioritized, or deferred to a lower level.

Pin inputs are synchronized, and then any change of level on them counts as an event. Timer, serial and monitor inputs are single-cycle strobes in the block's clock domain. A pending level stays set until the core acknowledges it while it is the granted level. A global enable gates the request but never the recording of new pending bits.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, `pend_o` is all zero and `irq_req_o` is low.
- R2: An edge of either direction on an enabled pin sets its level's pending bit on the third rising clock edge after the pin changes, and not earlier. Pins 0 and 1 map to level 1. Pins 2 and 3 map to level 6.
- R3: An enabled strobe that is high at a rising edge sets its level's pending bit at that edge. The strobe-to-level map is: evt 0 to level 2, evt 1 to level 3, evt 2 to level 4, evt 3, 4 and 5 to level 5, evt 6 to level 7.
- R4: A source whose bit in `src_en_i` is 0 never sets a pending bit. Bits 0 to 3 of `src_en_i` belong to pins 0 to 3, and bits 4 to 10 belong to evt 0 to 6.
- R5: When `sw_we_i` is high at a rising edge, the pending bits for levels 4..7 (if `sw_hi_i` is 1) or for levels 0..3 (if it is 0) are OR-ed with `sw_bits_i`. Level 0 is reachable only this way.
- R6: When a request is raised, `irq_lvl_o` is the highest-numbered pending level. Level 7 has the highest priority.
- R7: `irq_vec_o` is 0x040, 0x080, 0x0C0, 0x100, 0x140, 0x180, 0x1C0 or 0x1E0 for levels 0 to 7 respectively.
- R8: `irq_req_o` is high exactly when `ie_i` is high and at least one pending bit is set. Pending bits keep being recorded while `ie_i` is low.
- R9: `irq_ack_i` sampled high while `irq_req_o` is high clears only the granted level's pending bit. All other bits keep their value.
- R10: A set from hardware and from software on the same level in the same cycle leaves it pending. A set arriving in the same cycle as the acknowledge of that level also leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Asynchronous pin inputs, any-edge sensitive |
| evt_i | input | 7 | Synchronous single-cycle event strobes |
| src_en_i | input | 11 | Per-source enable (1 = enabled) |
| ie_i | input | 1 | Global interrupt enable |
| sw_we_i | input | 1 | Software pending-set strobe |
| sw_hi_i | input | 1 | Selects levels 4..7 (1) or 0..3 (0) for the write |
| sw_bits_i | input | 4 | Pending bits to set within the selected half |
| irq_ack_i | input | 1 | Core acknowledge of the granted level |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_lvl_o | output | 3 | Granted level |
| irq_vec_o | output | 9 | Vector address of the granted level |
| pend_o | output | 8 | Pending register |

## Verification
The assertions assume that `irq_ack_i` matters only while a request is shown. They also assume that no agent other than the acknowledge ever clears pending state. The stimulus raises acknowledge for a single cycle, and only after reading a request on the ports. The assertions also assume strobes and control inputs are synchronous to `clk`. The bench changes them only on falling edges, and it changes pins only when at least three cycles have passed since the previous pin change, so that each edge is seen once.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NUM_LVL  = 8;
  localparam int LVL_W    = $clog2(NUM_LVL);
  localparam int NUM_PIN  = 4;
  localparam int NUM_EVT  = 7;
  localparam int NUM_SRC  = NUM_PIN + NUM_EVT;
  localparam int VEC_W    = 9;
  localparam int SW_W     = NUM_LVL / 2;

  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [NUM_LVL-1:0] lvl_vec_t;
  typedef logic [VEC_W-1:0]   vec_t;

  // Level served by each source; pins occupy indices 0..NUM_PIN-1.
  function automatic lvl_t src_level(input int idx);
    case (idx)
      0, 1:    return lvl_t'(1);
      2, 3:    return lvl_t'(6);
      4:       return lvl_t'(2);
      5:       return lvl_t'(3);
      6:       return lvl_t'(4);
      7, 8, 9: return lvl_t'(5);
      default: return lvl_t'(7);
    endcase
  endfunction

  // Entry points are 64-byte spaced up to level 5, then 32-byte spaced.
  function automatic vec_t lvl_vector(input lvl_t lvl);
    vec_t v;
    if (lvl < lvl_t'(6)) v = vec_t'((int'(lvl) + 1) << 6);
    else                 v = vec_t'(9'h1C0 + ((int'(lvl) - 6) << 5));
    return v;
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_vec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lvl_vec_t set_i,
  input  lvl_vec_t clr_i,
  output lvl_vec_t pend_o
);
  lvl_vec_t pend_q, pend_d;
  logic     pend_en;

  // Set dominates clear so a new event during acknowledge is kept.
  always_comb begin
    pend_en = (|set_i) | (|clr_i);
    pend_d  = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_vec_pkg::*;
(
  input  lvl_vec_t pend_i,
  input  logic     ie_i,
  output logic     req_o,
  output lvl_t     lvl_o,
  output vec_t     vec_o
);
  lvl_t top;

  always_comb begin
    top = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (pend_i[i]) top = lvl_t'(i);
    end
    req_o = ie_i & (|pend_i);
    lvl_o = top;
    vec_o = lvl_vector(top);
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PIN-1:0]  pin_i,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic [NUM_SRC-1:0]  src_en_i,
  input  logic                ie_i,
  input  logic                sw_we_i,
  input  logic                sw_hi_i,
  input  logic [SW_W-1:0]     sw_bits_i,
  input  logic                irq_ack_i,
  output logic                irq_req_o,
  output logic [LVL_W-1:0]    irq_lvl_o,
  output logic [VEC_W-1:0]    irq_vec_o,
  output logic [NUM_LVL-1:0]  pend_o
);
  logic [NUM_PIN-1:0] pin_edge;
  logic [NUM_SRC-1:0] src_hit;
  lvl_vec_t           hw_set, sw_set, set_vec, clr_vec;

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i[p]),
      .edge_o (pin_edge[p])
    );
  end

  always_comb begin
    src_hit = {evt_i, pin_edge} & src_en_i;
    hw_set  = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_hit[s]) hw_set[src_level(s)] = 1'b1;
    end
    sw_set = '0;
    if (sw_we_i) begin
      if (sw_hi_i) sw_set[NUM_LVL-1:SW_W] = sw_bits_i;
      else         sw_set[SW_W-1:0]       = sw_bits_i;
    end
    set_vec = hw_set | sw_set;
    clr_vec = '0;
    if (irq_req_o && irq_ack_i) clr_vec[irq_lvl_o] = 1'b1;
  end

  irq_pend_reg u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend_o)
  );

  irq_prio_enc u_prio (
    .pend_i (pend_o),
    .ie_i   (ie_i),
    .req_o  (irq_req_o),
    .lvl_o  (irq_lvl_o),
    .vec_o  (irq_vec_o)
  );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ie_i,
  input logic       irq_ack_i,
  input logic       irq_req_o,
  input logic [2:0] irq_lvl_o,
  input logic [8:0] irq_vec_o,
  input logic [7:0] pend_o
);
  AST_REQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> ie_i); // R8

  AST_REQ_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_i && pend_o != 8'd0) |-> irq_req_o); // R8

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o == 8'd0) |-> !irq_req_o); // R1

  AST_GRANT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> ((pend_o >> irq_lvl_o) == 8'd1)); // R6

  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_vec_o[4:0] == 5'd0 && irq_vec_o >= 9'h040)); // R7

  AST_ONLY_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_o) & ~pend_o &
              ~(($past(irq_req_o) && $past(irq_ack_i)) ? (8'd1 << $past(irq_lvl_o)) : 8'd0)) == 8'd0)); // R9
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (.*);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pin_i;
  logic [6:0] evt_i;
  logic [10:0] src_en_i;
  logic       ie_i, sw_we_i, sw_hi_i, irq_ack_i;
  logic [3:0] sw_bits_i;
  logic       irq_req_o;
  logic [2:0] irq_lvl_o;
  logic [8:0] irq_vec_o;
  logic [7:0] pend_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vector_ctrl dut (.*);

  function automatic int lvl_of(input int s);
    int m [11] = '{1, 1, 6, 6, 2, 3, 4, 5, 5, 5, 7};
    return m[s];
  endfunction

  function automatic int top_of(input logic [7:0] p);
    int t = -1;
    for (int i = 0; i < 8; i++) if (p[i]) t = i;
    return t;
  endfunction

  function automatic int vec_of(input int l);
    if (l <= 5) return (l + 1) * 64;
    return 'h1C0 + (l - 6) * 32;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sw_write(input logic hi, input logic [3:0] b);
    sw_we_i = 1'b1; sw_hi_i = hi; sw_bits_i = b;
    cyc(1);
    sw_we_i = 1'b0; sw_bits_i = '0;
  endtask

  task automatic ack();
    irq_ack_i = 1'b1;
    cyc(1);
    irq_ack_i = 1'b0;
  endtask

  task automatic drain();
    while (pend_o != 8'd0) ack();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] expv;
    rst_n = 1'b0; pin_i = '0; evt_i = '0; src_en_i = '1; ie_i = 1'b1;
    sw_we_i = 1'b0; sw_hi_i = 1'b0; sw_bits_i = '0; irq_ack_i = 1'b0;
    cyc(3);
    chk(pend_o == 0 && !irq_req_o, "R1 in reset", pend_o, 0);
    rst_n = 1'b1;
    cyc(2);
    chk(pend_o == 0 && !irq_req_o, "R1 after reset", pend_o, 0);

    // Pins: rising then falling edge, each enabled then disabled
    for (int p = 0; p < 4; p++) begin
      for (int dir = 0; dir < 2; dir++) begin
        pin_i[p] = (dir == 0);
        cyc(2);
        chk(pend_o == 0, "R2 not before third edge", pend_o, 0);
        cyc(1);
        chk(pend_o == (8'd1 << lvl_of(p)), "R2 pin edge", pend_o, 8'd1 << lvl_of(p));
        drain();
      end
      src_en_i[p] = 1'b0;
      pin_i[p] = 1'b1; cyc(4);
      pin_i[p] = 1'b0; cyc(4);
      chk(pend_o == 0, "R4 disabled pin", pend_o, 0);
      src_en_i[p] = 1'b1;
    end

    // Strobes, enabled and disabled
    for (int e = 0; e < 7; e++) begin
      evt_i[e] = 1'b1; cyc(1); evt_i[e] = 1'b0;
      chk(pend_o == (8'd1 << lvl_of(e + 4)), "R3 strobe", pend_o, 8'd1 << lvl_of(e + 4));
      drain();
      src_en_i[e + 4] = 1'b0;
      evt_i[e] = 1'b1; cyc(1); evt_i[e] = 1'b0; cyc(1);
      chk(pend_o == 0, "R4 disabled strobe", pend_o, 0);
      src_en_i[e + 4] = 1'b1;
    end

    // All 255 patterns via software, drained in priority order
    for (int pat = 1; pat < 256; pat++) begin
      expv = 8'(pat);
      sw_write(1'b0, expv[3:0]);
      sw_write(1'b1, expv[7:4]);
      chk(pend_o == expv, "R5 software set", pend_o, expv);
      while (expv != 0) begin
        chk(irq_req_o == 1'b1, "R8 request when pending", irq_req_o, 1);
        chk(irq_lvl_o == 3'(top_of(expv)), "R6 highest level", irq_lvl_o, top_of(expv));
        chk(irq_vec_o == 9'(vec_of(top_of(expv))), "R7 vector", irq_vec_o, vec_of(top_of(expv)));
        expv[top_of(expv)] = 1'b0;
        ack();
        chk(pend_o == expv, "R9 ack clears only granted", pend_o, expv);
      end
      chk(!irq_req_o, "R8 no request when empty", irq_req_o, 0);
    end

    // Global enable low: recorded but not requested
    ie_i = 1'b0;
    evt_i[6] = 1'b1; cyc(1); evt_i[6] = 1'b0;
    sw_write(1'b0, 4'b0001);
    chk(pend_o == 8'h81 && !irq_req_o, "R8 ie low blocks request", {irq_req_o, pend_o}, 8'h81);
    ack();
    chk(pend_o == 8'h81, "R8 ack ignored without request", pend_o, 8'h81);
    ie_i = 1'b1; cyc(1);
    chk(irq_req_o && irq_lvl_o == 3'd7, "R8 request after enable", irq_lvl_o, 7);
    drain();

    // Same-cycle hardware and software set on one level
    evt_i[0] = 1'b1; sw_we_i = 1'b1; sw_hi_i = 1'b0; sw_bits_i = 4'b0100;
    cyc(1);
    evt_i[0] = 1'b0; sw_we_i = 1'b0; sw_bits_i = '0;
    chk(pend_o == 8'h04, "R10 hw and sw same level", pend_o, 8'h04);
    // New event during acknowledge of the same level
    evt_i[0] = 1'b1; irq_ack_i = 1'b1;
    cyc(1);
    evt_i[0] = 1'b0; irq_ack_i = 1'b0;
    chk(pend_o == 8'h04, "R10 set beats ack", pend_o, 8'h04);
    ack();
    chk(pend_o == 8'h00, "R9 final clear", pend_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule